// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer Bank

This block is a memory-mapped timer peripheral. A shared 16-bit prescaler divides the system clock into a tick. That tick drives a parameterised number of 32-bit down-counting channels (1 to 8, default 2). Software reaches every register through a simple 32-bit word port: one write strobe, one read strobe, a byte address and registered read data one cycle after the strobe.

Each channel counts down once per tick while enabled. It signals when the count passes below zero, not when it reaches zero. When it signals, it can reload itself and keep running, or it can stop. If interrupts are enabled for that channel, it raises a one-cycle pulse on its own interrupt output and sets a pending flag. Software clears that flag by writing one to it.

A read-only unit descriptor word reports the channel count, the base interrupt number and two fixed capability bits.

Top module: `timer_bank`

## Requirements
- R1: After reset every prescaler, counter, reload and control register reads zero and no interrupt output is high.
- R2: The prescaler value and prescaler reload registers (offsets 0x00 and 0x04) keep only bits [15:0] of written data. The prescaler issues one tick every (reload+1) clocks.
- R3: Offset 0x08 reads the channel count in bits [2:0], the base interrupt number in bits [7:3], and 1 in bits 8 and 9. With the defaults it reads 0x342, and writes to it have no effect.
- R4: Channel n sits at byte offset 0x10*(n+1), with its counter at +0, reload at +4 and control at +8. The control bits are: bit0 enable, bit1 auto-reload, bit2 load, bit3 interrupt enable, bit4 pending. A channel started with value V raises its interrupt exactly V+1 ticks later, for one cycle.
- R5: With auto-reload set, an underflowing channel takes its reload value R and keeps running, so it fires every (R+1)*(prescaler reload+1) clocks.
- R6: With auto-reload clear, an underflowing channel clears its enable bit, stops, and leaves its counter at 0xFFFFFFFF.
- R7: Pending is set on an interrupt. Writing 1 to bit4 of control clears pending, and writing 0 to it leaves pending unchanged. The load bit always reads 0.
- R8: With interrupt enable clear, an underflow neither pulses the interrupt output nor sets pending.
- R9: A write to the counter register sets the count. An enabled channel goes on counting from the written value, so writing V fires V+1 ticks later.
- R10: Reads of unmapped words, or of channels at or beyond the configured count, return zero, and writes to them change nothing.
- R11: When an underflow and a control write that clears pending land in the same cycle, pending ends set and the interrupt pulse is still issued.
- R12: A channel with enable clear holds its counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | NCH | One-cycle interrupt pulse per channel |

## Verification
Two functions can hit the same pending flag in the same cycle. One is the hardware underflow, which sets pending. The other is a software control write with bit4 high, which clears it. To provoke this, the bench runs a channel in auto-reload mode with a tick every clock, so its period is known. It synchronises to one interrupt pulse and then places the clearing write on the exact edge of the next underflow. The bench judges the outcome at the ports: the interrupt output must be high after that edge, and a control read must return pending set along with the written enable, reload and interrupt-enable bits.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  // word selectors inside a 16-byte slot (addr[3:2])
  localparam logic [1:0] SEL_W0 = 2'd0;  // prescaler value / channel counter
  localparam logic [1:0] SEL_W1 = 2'd1;  // prescaler reload / channel reload
  localparam logic [1:0] SEL_W2 = 2'd2;  // unit descriptor / channel control
  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_IE   = 3;
  localparam int CB_PEND = 4;
  localparam int CTL_W   = 5;
endpackage

// File: rtl/timer_bank_prescaler.sv
module timer_bank_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] val_o,
  output logic [PW-1:0] rld_o,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q, rld_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (wr_rld) rld_q <= wdata;
      if (wr_val)           cnt_q <= wdata;
      else if (cnt_q == '0) cnt_q <= rld_q;
      else                  cnt_q <= cnt_q - 1'b1;
      tick_q <= !wr_val && (cnt_q == '0);
    end
  end

  assign val_o  = cnt_q;
  assign rld_o  = rld_q;
  assign tick_o = tick_q;

  // R2: a non-zero count cannot produce a tick on the next edge
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> !tick_q);
endmodule

// File: rtl/timer_bank_channel.sv
module timer_bank_channel
  import timer_bank_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    rld_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  logic [CW-1:0] cnt_q, rld_q;
  logic en_q, auto_q, ie_q, pend_q, irq_q;
  logic uflow;

  assign uflow = tick && en_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= uflow && ie_q;
      if (wr_rld) rld_q <= wdata;
      if (uflow && ie_q)                pend_q <= 1'b1;
      else if (wr_ctl && wdata[CB_PEND]) pend_q <= 1'b0;
      if (wr_ctl) begin
        en_q   <= wdata[CB_EN];
        auto_q <= wdata[CB_AUTO];
        ie_q   <= wdata[CB_IE];
      end else if (uflow && !auto_q) begin
        en_q <= 1'b0;
      end
      if (wr_cnt)                        cnt_q <= wdata;
      else if (wr_ctl && wdata[CB_LOAD]) cnt_q <= rld_q;
      else if (uflow && auto_q)          cnt_q <= rld_q;
      else if (tick && en_q)             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = {pend_q, ie_q, 1'b0, auto_q, en_q};
  assign irq_o = irq_q;

  // R8: a pulse only follows a cycle with interrupts enabled
  p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ie_q));
  // R7: a pulse always leaves pending set (R11 collision included)
  p_pend_on_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pend_q);
  // R6: a one-shot channel is disabled when it fires
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !$past(auto_q) && !$past(wr_ctl)) |-> !en_q);
  // R12: a disabled channel without writes keeps its count
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_q) && !$past(wr_cnt) && !$past(wr_ctl)) |-> $stable(cnt_q));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int IRQ_BASE = 8,
  parameter int ADDR_W   = 8,
  parameter int PW       = 16,
  parameter int CW       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    irq
);
  localparam int SW = ADDR_W - 4;
  localparam logic [31:0] DESC = 32'(NCH % 8) | (32'(IRQ_BASE % 32) << 3)
                               | (32'd1 << 8) | (32'd1 << 9);

  logic [SW-1:0] slot;
  logic [1:0]    sel;
  assign slot = addr[ADDR_W-1:4];
  assign sel  = addr[3:2];

  logic [PW-1:0] ps_val, ps_rld;
  logic          tick;

  timer_bank_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst),
    .wr_val(wr_en && slot == '0 && sel == SEL_W0),
    .wr_rld(wr_en && slot == '0 && sel == SEL_W1),
    .wdata(wdata[PW-1:0]),
    .val_o(ps_val), .rld_o(ps_rld), .tick_o(tick)
  );

  logic [CW-1:0]    ch_cnt [NCH];
  logic [CW-1:0]    ch_rld [NCH];
  logic [CTL_W-1:0] ch_ctl [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (slot == SW'(i + 1));
    timer_bank_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .tick(tick),
      .wr_cnt(hit && sel == SEL_W0),
      .wr_rld(hit && sel == SEL_W1),
      .wr_ctl(hit && sel == SEL_W2),
      .wdata(wdata[CW-1:0]),
      .cnt_o(ch_cnt[i]), .rld_o(ch_rld[i]), .ctl_o(ch_ctl[i]),
      .irq_o(irq[i])
    );
  end

  logic [31:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    if (slot == '0) begin
      case (sel)
        SEL_W0:  rd_mux = 32'(ps_val);
        SEL_W1:  rd_mux = 32'(ps_rld);
        SEL_W2:  rd_mux = DESC;
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (slot == SW'(i + 1)) begin
        case (sel)
          SEL_W0:  rd_mux = 32'(ch_cnt[i]);
          SEL_W1:  rd_mux = 32'(ch_rld[i]);
          SEL_W2:  rd_mux = 32'(ch_ctl[i]);
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;

  logic hole;
  assign hole = (sel == 2'd3) || (slot > SW'(NCH));

  // R10: unmapped words read as zero
  p_hole_zero_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(hole)) |-> (rdata == '0));
  // R3: descriptor word is fixed
  p_desc_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == ADDR_W'(8)) |-> (rdata == DESC));
endmodule

// File: tb/timer_bank_bench.sv
module timer_bank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  always #2.5 clk = ~clk;

  timer_bank u_timer_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: pops expected read data as each result appears
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata === e, t, rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic cycles_to_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input int ch, input int len, input string t);
    bit seen = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (irq[ch]) seen = 1'b1;
    end
    check(!seen, t, 32'(seen), 32'd0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", 32'(irq), 32'd0);
    rd(8'h00, 32'h0, "R1 prescaler value");
    rd(8'h04, 32'h0, "R1 prescaler reload");
    rd(8'h10, 32'h0, "R1 ch0 counter");
    rd(8'h14, 32'h0, "R1 ch0 reload");
    rd(8'h18, 32'h0, "R1 ch0 control");
    rd(8'h28, 32'h0, "R1 ch1 control");
    // R3 descriptor
    rd(8'h08, 32'h342, "R3 descriptor");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h342, "R3 descriptor after write");
    // R2 16-bit masking
    wr(8'h04, 32'h0001_2345);
    rd(8'h04, 32'h2345, "R2 reload mask");
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);
    // R4 one-shot latency V+1 ticks (tick every clock)
    wr(8'h14, 32'd5);
    wr(8'h18, 32'h0D);
    cycles_to_irq(0, n);
    check(n == 6, "R4 fire after V+1 ticks", 32'(n), 32'd6);
    @(negedge clk);
    check(irq[0] == 1'b0, "R4 one-cycle pulse", 32'(irq[0]), 32'd0);
    // R6 one-shot stops
    rd(8'h10, 32'hFFFF_FFFF, "R6 counter after underflow");
    rd(8'h18, 32'h18, "R6/R7 control: enable cleared, pending set, load 0");
    quiet(0, 20, "R6 no further irq");
    // R7 sticky pending
    wr(8'h18, 32'h08);
    rd(8'h18, 32'h18, "R7 write 0 keeps pending");
    wr(8'h18, 32'h18);
    rd(8'h18, 32'h08, "R7 write 1 clears pending");
    // R8 no interrupt when disabled
    wr(8'h24, 32'd3);
    wr(8'h28, 32'h07);
    quiet(1, 20, "R8 no irq with ie clear");
    rd(8'h28, 32'h03, "R8 no pending with ie clear");
    wr(8'h28, 32'h00);
    // R5 auto-reload period with prescaler reload 2
    wr(8'h04, 32'd2);
    wr(8'h00, 32'd0);
    wr(8'h14, 32'd3);
    wr(8'h18, 32'h0F);
    cycles_to_irq(0, n);
    @(negedge clk);
    cycles_to_irq(0, n);
    check(n + 1 == 12, "R5 period (R+1)*(P+1)", 32'(n + 1), 32'd12);
    @(negedge clk);
    cycles_to_irq(0, n);
    check(n + 1 == 12, "R5 second period", 32'(n + 1), 32'd12);
    // R11 collision: tick each clock, period 4
    wr(8'h04, 32'd0);
    wr(8'h00, 32'd0);
    cycles_to_irq(0, n);
    @(negedge clk);
    cycles_to_irq(0, n);
    check(n + 1 == 4, "R5 period with P=0", 32'(n + 1), 32'd4);
    repeat (3) @(negedge clk);
    wr(8'h18, 32'h1B);
    check(irq[0] == 1'b1, "R11 pulse on collision", 32'(irq[0]), 32'd1);
    rd(8'h18, 32'h1B, "R11 pending survives clear");
    wr(8'h18, 32'h00);
    wr(8'h18, 32'h10);
    rd(8'h18, 32'h00, "R7 clear when stopped");
    // R12 disabled channel holds counter
    wr(8'h10, 32'd100);
    repeat (10) @(negedge clk);
    rd(8'h10, 32'd100, "R12 counter held");
    // R9 counter write restarts counting
    wr(8'h18, 32'h09);
    wr(8'h10, 32'd2);
    cycles_to_irq(0, n);
    check(n == 3, "R9 fire V+1 after counter write", 32'(n), 32'd3);
    wr(8'h18, 32'h10);
    // R10 holes
    wr(8'h34, 32'h55);
    wr(8'h1C, 32'h77);
    wr(8'h0C, 32'h1);
    rd(8'h34, 32'h0, "R10 channel beyond count");
    rd(8'h1C, 32'h0, "R10 unused channel word");
    rd(8'h0C, 32'h0, "R10 unused unit word");
    rd(8'h80, 32'h0, "R10 far address");
    rd(8'h14, 32'd3, "R10 ch0 reload untouched");
    rd(8'h24, 32'd3, "R10 ch1 reload untouched");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule